// File: doc/BRIEF.md
# Hiccup Fault Recovery Sequencer

This block sequences start-up and fault recovery for a group of switching converter channels. It watches a short-circuit flag and two digitised overvoltage flags on each channel, together with that channel's dimming input and a global enable. It produces one global inhibit for the gate and disconnect drivers, a clamp that holds the compensation nodes low, and a discharge command for the restart timing node. The analog timing capacitor is modelled as a counter. The counter first runs for a discharge period and then for a charge period, and the charge period sets the restart (hiccup) time.

After enable, and after any fault, the sequencer discharges the timing node for a fixed number of cycles. It then waits until every fault has gone, and then charges for the programmed hiccup time. Only after the charge does it release the clamp and the drivers. If a fault appears while the node is charging, the full discharge restarts. A short-circuit flag is masked for a fixed window after each rising edge of that channel's dimming input, so that the current spike at turn-on does not trip the sequencer. Each channel's overvoltage input is held in a hysteretic latch. The latch sets when the flag reports that the upper threshold has been crossed, and it clears only when the flag reports that the lower threshold has been crossed.

Top module: `hiccup_seq`

## Requirements
- R1: While reset is asserted and directly after it, `seq_state` is 0 (standby) and `drv_inhibit`, `comp_clamp` and `tmr_dis` are all 1.
- R2: When `en` is sampled low at a clock edge, the sequencer is in standby after that edge, with `drv_inhibit`, `comp_clamp` and `tmr_dis` all 1. This holds from any state.
- R3: When `en` is sampled high in standby, the sequencer moves to discharge (state 1). It stays there for exactly DISCH_CYC cycles with `tmr_dis` at 1.
- R4: At the end of discharge, the sequencer enters charge (state 3) only if no fault is present. Otherwise it enters wait-clear (state 2) with `tmr_dis` at 1, and it leaves wait-clear for charge at the first edge with no fault.
- R5: Charge lasts CHARGE_CYC cycles with `tmr_dis` at 0 and `comp_clamp` and `drv_inhibit` at 1. After charge comes run (state 4), where all three outputs are 0.
- R6: A fault during charge returns the sequencer to discharge at the next edge, and a full DISCH_CYC discharge follows.
- R7: A fault during run returns the sequencer to discharge at the next edge.
- R8: A channel's short-circuit flag is ignored for BLANK_CYC cycles. The window begins with the first cycle in which that channel's dimming input is sampled high after being low. Each new rising edge restarts the window.
- R9: Outside the blanking window, a short-circuit flag is a fault in the same cycle. This includes the case where the dimming input is held steady.
- R10: A channel's overvoltage latch sets when `ovr_in` is high and clears when `ovf_in` is high and `ovr_in` is low. If both are high, the latch sets. The set latch is a fault, which the sequencer acts on one edge after the edge that sampled `ovr_in`.
- R11: The `seq_state` encoding is standby=0, discharge=1, wait-clear=2, charge=3, run=4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Global enable; low forces standby |
| dim_in | input | NCH | Per-channel dimming input |
| sc_in | input | NCH | Per-channel short-circuit flag |
| ovr_in | input | NCH | Per-channel flag: output above the upper overvoltage threshold |
| ovf_in | input | NCH | Per-channel flag: output below the lower overvoltage threshold |
| drv_inhibit | output | 1 | Holds all gate and disconnect drivers off |
| comp_clamp | output | 1 | Pulls the compensation nodes low |
| tmr_dis | output | 1 | Discharges the restart timing node |
| seq_state | output | 3 | Sequencer state, encoded as in R11 |

## Verification
Every output of this block is decoded from the registered state. A short-circuit flag therefore shows in the outputs one edge after it is sampled. An overvoltage flag takes two edges, because it first passes through its latch. A dimming rising edge masks short flags for BLANK_CYC consecutive edges, counting the edge that sees it. The bench drives inputs at falling edges and reads outputs at the next falling edge. Its expected values come from a behavioural model that is stepped at each rising edge, and from directed checks whose edge counts are worked out from these latencies.

// File: rtl/hiccup_pkg.sv
package hiccup_pkg;
  typedef enum logic [2:0] {
    ST_STANDBY    = 3'd0,
    ST_DISCHARGE  = 3'd1,
    ST_WAIT_CLEAR = 3'd2,
    ST_CHARGE     = 3'd3,
    ST_RUN        = 3'd4
  } seq_state_t;
endpackage

// File: rtl/hiccup_sc_blank.sv
module hiccup_sc_blank #(
  parameter int BLANK_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dim,
  input  logic sc,
  output logic sc_ok
);
  localparam int BW = $clog2(BLANK_CYC + 1);

  logic          dim_q;
  logic [BW-1:0] cnt, cnt_nxt;
  logic          rise;

  assign rise  = dim & ~dim_q;
  assign sc_ok = sc & ~rise & (cnt == '0);

  always_comb begin
    if (rise)            cnt_nxt = BW'(BLANK_CYC - 1);
    else if (cnt != '0)  cnt_nxt = cnt - 1'b1;
    else                 cnt_nxt = cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dim_q <= 1'b0;
      cnt   <= '0;
    end else begin
      dim_q <= dim;
      cnt   <= cnt_nxt;
    end
  end

  AST_BLANK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> (cnt == BW'(BLANK_CYC - 1))); // R8
  AST_BLANK_DECAY: assert property (@(posedge clk) disable iff (!rst_n)
    (!rise && cnt != '0) |=> (cnt == $past(cnt) - 1'b1)); // R8
endmodule

// File: rtl/hiccup_ov_latch.sv
module hiccup_ov_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic ovr,
  input  logic ovf,
  output logic lat
);
  logic lat_nxt;

  always_comb begin
    if (ovr)      lat_nxt = 1'b1;
    else if (ovf) lat_nxt = 1'b0;
    else          lat_nxt = lat;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat <= 1'b0;
    else        lat <= lat_nxt;
  end

  AST_OV_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ovr |=> lat); // R10
  AST_OV_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !ovr) |=> !lat); // R10
  AST_OV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovf && !ovr) |=> $stable(lat)); // R10
endmodule

// File: rtl/hiccup_timer.sv
module hiccup_timer #(
  parameter int DISCH_CYC  = 16,
  parameter int CHARGE_CYC = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic dis_done,
  output logic chg_done
);
  localparam int MAXC = (DISCH_CYC > CHARGE_CYC) ? DISCH_CYC : CHARGE_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  logic [CW-1:0] cnt, cnt_nxt;

  assign dis_done = (cnt == CW'(DISCH_CYC - 1));
  assign chg_done = (cnt == CW'(CHARGE_CYC - 1));

  always_comb begin
    if (clr)      cnt_nxt = '0;
    else if (inc) cnt_nxt = cnt + 1'b1;
    else          cnt_nxt = cnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nxt;
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CW'(MAXC)); // R5
endmodule

// File: rtl/hiccup_seq.sv
module hiccup_seq #(
  parameter int NCH        = 3,
  parameter int DISCH_CYC  = 16,
  parameter int CHARGE_CYC = 64,
  parameter int BLANK_CYC  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic [NCH-1:0] dim_in,
  input  logic [NCH-1:0] sc_in,
  input  logic [NCH-1:0] ovr_in,
  input  logic [NCH-1:0] ovf_in,
  output logic           drv_inhibit,
  output logic           comp_clamp,
  output logic           tmr_dis,
  output logic [2:0]     seq_state
);
  import hiccup_pkg::*;

  seq_state_t     state, state_nxt;
  logic [NCH-1:0] sc_ok, ov_lat;
  logic           fault, t_clr, t_inc, dis_done, chg_done;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    hiccup_sc_blank #(.BLANK_CYC(BLANK_CYC)) u_blank (
      .clk(clk), .rst_n(rst_n), .dim(dim_in[c]), .sc(sc_in[c]), .sc_ok(sc_ok[c])
    );
    hiccup_ov_latch u_ov (
      .clk(clk), .rst_n(rst_n), .ovr(ovr_in[c]), .ovf(ovf_in[c]), .lat(ov_lat[c])
    );
  end

  assign fault = (|sc_ok) | (|ov_lat);

  hiccup_timer #(.DISCH_CYC(DISCH_CYC), .CHARGE_CYC(CHARGE_CYC)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clr(t_clr), .inc(t_inc),
    .dis_done(dis_done), .chg_done(chg_done)
  );

  always_comb begin
    state_nxt = state;
    if (!en) begin
      state_nxt = ST_STANDBY;
    end else begin
      case (state)
        ST_STANDBY:    state_nxt = ST_DISCHARGE;
        ST_DISCHARGE:  if (dis_done) state_nxt = fault ? ST_WAIT_CLEAR : ST_CHARGE;
        ST_WAIT_CLEAR: if (!fault) state_nxt = ST_CHARGE;
        ST_CHARGE:     if (fault) state_nxt = ST_DISCHARGE;
                       else if (chg_done) state_nxt = ST_RUN;
        ST_RUN:        if (fault) state_nxt = ST_DISCHARGE;
        default:       state_nxt = ST_STANDBY;
      endcase
    end
  end

  assign t_clr = (state_nxt != state);
  assign t_inc = (state == ST_DISCHARGE) || (state == ST_CHARGE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_STANDBY;
    else        state <= state_nxt;
  end

  assign drv_inhibit = (state != ST_RUN);
  assign comp_clamp  = (state != ST_RUN);
  assign tmr_dis     = (state == ST_STANDBY) || (state == ST_DISCHARGE) ||
                       (state == ST_WAIT_CLEAR);
  assign seq_state   = state;

  AST_EN_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (state == ST_STANDBY)); // R2
  AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (en && state == ST_WAIT_CLEAR && fault) |=> (state == ST_WAIT_CLEAR)); // R4
  AST_CHG_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (en && state == ST_CHARGE && fault) |=> (state == ST_DISCHARGE)); // R6
  AST_RUN_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (en && state == ST_RUN && fault) |=> (state == ST_DISCHARGE)); // R7
  AST_RUN_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && $past(state) != ST_RUN) |-> ($past(state) == ST_CHARGE)); // R5
endmodule

// File: tb/tb_hiccup_seq.sv
module tb_hiccup_seq;
  localparam int NCH = 3;
  localparam int D   = 6;
  localparam int C   = 20;
  localparam int B   = 5;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           en = 1'b0;
  logic [NCH-1:0] dim_in = '0, sc_in = '0, ovr_in = '0, ovf_in = '0;
  logic           drv_inhibit, comp_clamp, tmr_dis;
  logic [2:0]     seq_state;

  int  total = 0, bad = 0;
  bit  done = 0;

  always #5 clk = ~clk;

  hiccup_seq #(.NCH(NCH), .DISCH_CYC(D), .CHARGE_CYC(C), .BLANK_CYC(B)) dut (
    .clk(clk), .rst_n(rst_n), .en(en), .dim_in(dim_in), .sc_in(sc_in),
    .ovr_in(ovr_in), .ovf_in(ovf_in), .drv_inhibit(drv_inhibit),
    .comp_clamp(comp_clamp), .tmr_dis(tmr_dis), .seq_state(seq_state)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // behavioural reference model
  int m_state, m_cnt;
  int m_blank [NCH];
  bit m_dimq  [NCH];
  bit m_ovl   [NCH];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0; m_cnt = 0;
      for (int c = 0; c < NCH; c++) begin m_blank[c] = 0; m_dimq[c] = 0; m_ovl[c] = 0; end
    end else begin
      bit f;
      int ns;
      f = 0;
      for (int c = 0; c < NCH; c++) begin
        bit rise;
        rise = dim_in[c] && !m_dimq[c];
        if (sc_in[c] && !rise && m_blank[c] == 0) f = 1;
        if (m_ovl[c]) f = 1;
      end
      ns = m_state;
      if (!en) ns = 0;
      else if (m_state == 0) ns = 1;
      else if (m_state == 1) begin if (m_cnt == D - 1) ns = f ? 2 : 3; end
      else if (m_state == 2) begin if (!f) ns = 3; end
      else if (m_state == 3) begin if (f) ns = 1; else if (m_cnt == C - 1) ns = 4; end
      else if (m_state == 4) begin if (f) ns = 1; end
      if (ns != m_state) m_cnt = 0;
      else if (m_state == 1 || m_state == 3) m_cnt++;
      m_state = ns;
      for (int c = 0; c < NCH; c++) begin
        if (dim_in[c] && !m_dimq[c]) m_blank[c] = B - 1;
        else if (m_blank[c] > 0) m_blank[c]--;
        m_dimq[c] = dim_in[c];
        if (ovr_in[c]) m_ovl[c] = 1;
        else if (ovf_in[c]) m_ovl[c] = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      chk("R11 model state", int'(seq_state), m_state);
      chk("R5 model inhibit", int'(drv_inhibit), int'(m_state != 4));
      chk("R5 model clamp", int'(comp_clamp), int'(m_state != 4));
      chk("R3 model tmr_dis", int'(tmr_dis), int'(m_state <= 2));
    end
  end

  initial begin
    #(10 * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finish");
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    step(2);
    chk("R1 reset state", int'(seq_state), 0);
    chk("R1 reset inhibit", int'(drv_inhibit), 1);
    chk("R1 reset clamp", int'(comp_clamp), 1);
    chk("R1 reset tmr_dis", int'(tmr_dis), 1);
    rst_n = 1'b1;
    step(2);
    chk("R1 standby after reset", int'(seq_state), 0);

    // start-up
    en = 1'b1;
    step(1);
    chk("R3 discharge entry", int'(seq_state), 1);
    chk("R3 tmr_dis in discharge", int'(tmr_dis), 1);
    step(D - 1);
    chk("R3 still discharging", int'(seq_state), 1);
    step(1);
    chk("R4 charge after clean discharge", int'(seq_state), 3);
    chk("R5 tmr_dis low in charge", int'(tmr_dis), 0);
    chk("R5 clamp in charge", int'(comp_clamp), 1);
    step(C - 1);
    chk("R5 still charging", int'(seq_state), 3);
    step(1);
    chk("R5 run entry", int'(seq_state), 4);
    chk("R5 inhibit released", int'(drv_inhibit), 0);

    // blanking after dimming rise
    dim_in[0] = 1'b1; sc_in[0] = 1'b1;
    step(B);
    chk("R8 short blanked", int'(seq_state), 4);
    sc_in[0] = 1'b0;
    step(1);
    sc_in[0] = 1'b1;
    step(1);
    chk("R9 short after window", int'(seq_state), 1);
    chk("R7 run fault to discharge", int'(drv_inhibit), 1);
    sc_in[0] = 1'b0; sc_in[1] = 1'b1;
    step(D);
    chk("R4 wait clear with fault", int'(seq_state), 2);
    chk("R4 tmr_dis in wait", int'(tmr_dis), 1);
    step(3);
    chk("R4 wait holds", int'(seq_state), 2);
    sc_in[1] = 1'b0;
    step(1);
    chk("R4 charge after clear", int'(seq_state), 3);
    step(5);
    sc_in[2] = 1'b1;
    step(1);
    chk("R6 charge fault", int'(seq_state), 1);
    sc_in[2] = 1'b0;
    step(D - 1);
    chk("R6 full discharge", int'(seq_state), 1);
    step(1);
    chk("R6 recharge", int'(seq_state), 3);
    step(C);
    chk("R5 run again", int'(seq_state), 4);

    // overvoltage hysteresis
    ovr_in[1] = 1'b1;
    step(1);
    ovr_in[1] = 1'b0;
    chk("R10 latch lag", int'(seq_state), 4);
    step(1);
    chk("R10 overvoltage fault", int'(seq_state), 1);
    step(D + 3);
    chk("R10 latch holds", int'(seq_state), 2);
    ovf_in[1] = 1'b1;
    step(1);
    chk("R10 clear lag", int'(seq_state), 2);
    ovf_in[1] = 1'b0;
    step(1);
    chk("R10 recovery", int'(seq_state), 3);

    // enable low
    step(2);
    en = 1'b0;
    step(1);
    chk("R2 standby", int'(seq_state), 0);
    chk("R2 inhibit", int'(drv_inhibit), 1);
    chk("R2 tmr_dis", int'(tmr_dis), 1);
    en = 1'b1;
    step(1);
    chk("R3 restart from standby", int'(seq_state), 1);

    // random phase checked against the model
    for (int i = 0; i < 4000; i++) begin
      for (int c = 0; c < NCH; c++) begin
        if ($urandom_range(0, 15) == 0) dim_in[c] = ~dim_in[c];
        sc_in[c]  = ($urandom_range(0, 149) == 0);
        ovr_in[c] = ($urandom_range(0, 399) == 0);
        ovf_in[c] = ($urandom_range(0, 7) == 0);
      end
      en = ($urandom_range(0, 299) != 0);
      step(1);
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule